// File: doc/BRIEF.md
# Branch History Target Table

This block is a small direct-mapped prediction table that the fetch stage consults every cycle. The fetch stage presents the address it is about to fetch. In the same cycle the table reports whether that address is a known branch, whether the branch is expected to be taken, and which address fetch should use next. On a miss or a not-taken prediction, that next address is the sequential one (current PC plus 4). On a taken prediction it is the stored target.

Each entry records the upper address bits of a branch, a one-bit record of that branch's last outcome, and its last taken target. The execute stage reports every resolved branch: its PC, whether it was taken, and its target. The table allocates or refreshes the matching entry on the next clock edge. In the cycle after a resolution, the table raises a flag if the next address it would have predicted for that branch differs from the real one. The pipeline then discards the instructions it fetched on the wrong path. The table itself flushes nothing.

Top module: `branch_target_table`

## Requirements
- R1: After reset every lookup misses: `fetch_hit` and `fetch_taken` are 0 and `fetch_next` equals `fetch_pc + 4`.
- R2: A resolved taken branch whose PC misses allocates an entry. From the next cycle, a lookup of that PC hits, predicts taken and returns the reported target on `fetch_next`.
- R3: A resolved not-taken branch whose PC misses allocates nothing, so a later lookup of that PC still misses.
- R4: A resolved not-taken branch that hits sets the entry's history to not taken. Later lookups then hit, do not predict taken, and return `fetch_pc + 4`.
- R5: A resolved taken branch that hits sets the history to taken and replaces the stored target with the reported one.
- R6: The table is indexed by PC bits [5:2] and tagged with PC bits [31:6]. A PC with the same index but a different tag misses. When such a PC resolves taken, it evicts the resident entry, and the old branch misses afterwards.
- R7: Lookup is combinational, and updates take effect only at the clock edge. A lookup made in the same cycle as a resolution to the same entry sees the entry as it was before that resolution.
- R8: `mispredict` is 1 in the cycle after a resolution exactly when the predicted next address for the resolved PC differs from the actual next address. The predicted next address is the stored target when the lookup hits with taken history, and PC+4 otherwise. The actual next address is the reported target if taken, and PC+4 otherwise. In every other cycle `mispredict` is 0.
- R9: PC bits [1:0] take no part in indexing or tagging. A lookup differing from an allocated PC only in those bits hits.
- R10: Asserting `rst` for a cycle clears every entry and `mispredict`, even after entries were allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address being fetched |
| fetch_hit | output | 1 | The address matches a valid entry |
| fetch_taken | output | 1 | Predicted taken (hit with taken history) |
| fetch_next | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A branch resolution is reported this cycle |
| res_pc | input | 32 | PC of the resolved branch |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| res_target | input | 32 | Actual target of the resolved branch |
| mispredict | output | 1 | Registered flag: the last resolution was mispredicted |

## Verification
The directed sequence drives the allocating and non-allocating miss cases, then flips one branch between taken and not taken to show that the one-bit history follows each outcome. It also retargets a taken branch, which separates a target-only misprediction from a direction misprediction. Two PCs that share an index but differ in tag show eviction versus aliasing. A lookup made in the same cycle as a resolution shows that the lookup sees the old entry. A randomized stretch over a few colliding and non-colliding PCs then compares all four outputs with a behavioural model on every clock.

// File: rtl/btt_pkg.sv
package btt_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_ALLOC  = 2'd1,
    ACT_UPDATE = 2'd2
  } btt_act_e;
endpackage

// File: rtl/btt_store.sv
module btt_store #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic [TAG_W-1:0]  a_tag,
  output logic              a_hist,
  output logic [ADDR_W-1:0] a_tgt,
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic [TAG_W-1:0]  b_tag,
  output logic              b_hist,
  output logic [ADDR_W-1:0] b_tgt,
  input  logic              wr_en,
  input  logic              wr_tgt_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_hist,
  input  logic [ADDR_W-1:0] wr_tgt
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem  [ENTRIES];
  logic               hist_mem [ENTRIES];
  logic [ADDR_W-1:0]  tgt_mem  [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      hist_mem[wr_idx] <= wr_hist;
    end
    if (wr_en && wr_tgt_en) tgt_mem[wr_idx] <= wr_tgt;
  end

  assign a_valid = valid_q[a_idx];
  assign a_tag   = tag_mem[a_idx];
  assign a_hist  = hist_mem[a_idx];
  assign a_tgt   = tgt_mem[a_idx];
  assign b_valid = valid_q[b_idx];
  assign b_tag   = tag_mem[b_idx];
  assign b_hist  = hist_mem[b_idx];
  assign b_tgt   = tgt_mem[b_idx];
endmodule

// File: rtl/btt_lookup.sv
module btt_lookup #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic              ent_hist,
  input  logic [ADDR_W-1:0] ent_tgt,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag,
  output logic              hit,
  output logic              taken,
  output logic [ADDR_W-1:0] next_pc
);
  assign idx     = pc[IDX_W+1:2];
  assign tag     = pc[ADDR_W-1:IDX_W+2];
  assign hit     = ent_valid && (ent_tag == tag);
  assign taken   = hit && ent_hist;
  assign next_pc = taken ? ent_tgt : pc + ADDR_W'(4);
endmodule

// File: rtl/btt_update.sv
module btt_update
  import btt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic              res_hit,
  input  logic [ADDR_W-1:0] res_pred_next,
  output logic              wr_en,
  output logic              wr_tgt_en,
  output logic              wr_hist,
  output logic              mispredict
);
  btt_act_e          act;
  logic [ADDR_W-1:0] actual_next;
  logic              mp_q;

  always_comb begin
    act = ACT_NONE;
    if (res_valid) begin
      if (res_hit)        act = ACT_UPDATE;
      else if (res_taken) act = ACT_ALLOC;
    end
  end

  assign wr_en       = (act != ACT_NONE);
  assign wr_tgt_en   = res_taken;
  assign wr_hist     = res_taken;
  assign actual_next = res_taken ? res_target : res_pc + ADDR_W'(4);

  always_ff @(posedge clk) begin
    if (rst) mp_q <= 1'b0;
    else     mp_q <= res_valid && (res_pred_next != actual_next);
  end

  assign mispredict = mp_q;
endmodule

// File: rtl/branch_target_table.sv
module branch_target_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              fetch_hit,
  output logic              fetch_taken,
  output logic [ADDR_W-1:0] fetch_next,
  input  logic              res_valid,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  output logic              mispredict
);
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  logic [IDX_W-1:0]  f_idx, r_idx;
  logic [TAG_W-1:0]  f_tag, r_tag, fe_tag, re_tag;
  logic              fe_valid, fe_hist, re_valid, re_hist;
  logic [ADDR_W-1:0] fe_tgt, re_tgt;
  logic              r_hit, r_taken;
  logic [ADDR_W-1:0] r_next;
  logic              wr_en, wr_tgt_en, wr_hist;

  btt_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_fetch_lk (
    .pc(fetch_pc), .ent_valid(fe_valid), .ent_tag(fe_tag), .ent_hist(fe_hist),
    .ent_tgt(fe_tgt), .idx(f_idx), .tag(f_tag), .hit(fetch_hit),
    .taken(fetch_taken), .next_pc(fetch_next)
  );

  btt_lookup #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_res_lk (
    .pc(res_pc), .ent_valid(re_valid), .ent_tag(re_tag), .ent_hist(re_hist),
    .ent_tgt(re_tgt), .idx(r_idx), .tag(r_tag), .hit(r_hit),
    .taken(r_taken), .next_pc(r_next)
  );

  btt_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .a_idx(f_idx), .a_valid(fe_valid), .a_tag(fe_tag), .a_hist(fe_hist), .a_tgt(fe_tgt),
    .b_idx(r_idx), .b_valid(re_valid), .b_tag(re_tag), .b_hist(re_hist), .b_tgt(re_tgt),
    .wr_en(wr_en), .wr_tgt_en(wr_tgt_en), .wr_idx(r_idx), .wr_tag(r_tag),
    .wr_hist(wr_hist), .wr_tgt(res_target)
  );

  btt_update #(.ADDR_W(ADDR_W)) u_update (
    .clk(clk), .rst(rst), .res_valid(res_valid), .res_pc(res_pc),
    .res_taken(res_taken), .res_target(res_target), .res_hit(r_hit),
    .res_pred_next(r_next), .wr_en(wr_en), .wr_tgt_en(wr_tgt_en),
    .wr_hist(wr_hist), .mispredict(mispredict)
  );

  logic unused_r_taken;
  assign unused_r_taken = r_taken;
endmodule

// File: rtl/btt_checker.sv
module btt_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              fetch_hit,
  input logic              fetch_taken,
  input logic [ADDR_W-1:0] fetch_next,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_pc,
  input logic              res_taken,
  input logic [ADDR_W-1:0] res_target,
  input logic              mispredict
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !fetch_hit && !mispredict); // R10

  AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (rst)
    !fetch_hit |-> !fetch_taken && (fetch_next == fetch_pc + ADDR_W'(4))); // R1

  AST_TAKEN_ALLOCATES: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_taken |=> (fetch_pc != $past(res_pc)) ||
      (fetch_hit && fetch_taken && fetch_next == $past(res_target))); // R2

  AST_NOT_TAKEN_FALLS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_taken |=> (fetch_pc != $past(res_pc)) || !fetch_taken); // R4

  AST_FLAG_NEEDS_RESOLVE: assert property (@(posedge clk) disable iff (rst)
    mispredict |-> $past(res_valid)); // R8
endmodule

bind branch_target_table btt_checker #(.ADDR_W(ADDR_W)) u_btt_checker (
  .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
  .fetch_taken(fetch_taken), .fetch_next(fetch_next), .res_valid(res_valid),
  .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
  .mispredict(mispredict)
);

// File: tb/branch_target_table_test.sv
module branch_target_table_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] fetch_pc;
  logic        fetch_hit, fetch_taken, mispredict;
  logic [31:0] fetch_next;
  logic        res_valid, res_taken;
  logic [31:0] res_pc, res_target;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  branch_target_table uut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .fetch_hit(fetch_hit),
    .fetch_taken(fetch_taken), .fetch_next(fetch_next), .res_valid(res_valid),
    .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
    .mispredict(mispredict)
  );

  // behavioural reference
  bit          m_v   [int];
  int unsigned m_tag [int];
  bit          m_h   [int];
  int unsigned m_t   [int];
  bit          m_mp;

  function automatic int m_idx(input int unsigned pc);
    return int'((pc >> 2) % 16);
  endfunction

  function automatic bit m_hit(input int unsigned pc);
    int i = m_idx(pc);
    return m_v.exists(i) && m_v[i] && (m_tag[i] == (pc >> 6));
  endfunction

  function automatic int unsigned m_next(input int unsigned pc);
    int i = m_idx(pc);
    if (m_hit(pc) && m_h[i]) return m_t[i];
    return pc + 4;
  endfunction

  task automatic check(input string req, input string what, input int unsigned act, input int unsigned exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input string req, input bit r, input int unsigned fpc,
                      input bit rv, input int unsigned rpc, input bit rt, input int unsigned rtg);
    @(negedge clk);
    rst = r; fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt; res_target = rtg;
    #5;
    if (!r) begin
      check(req, "hit",   32'(fetch_hit),   32'(m_hit(fpc)));
      check(req, "taken", 32'(fetch_taken), 32'(m_hit(fpc) && m_h[m_idx(fpc)]));
      check(req, "next",  fetch_next,       m_next(fpc));
      check(req, "mispredict", 32'(mispredict), 32'(m_mp));
    end
    @(posedge clk);
    if (r) begin
      m_v.delete(); m_mp = 1'b0;
    end else begin
      int i = m_idx(rpc);
      bit h = m_hit(rpc);
      m_mp = rv && (m_next(rpc) != (rt ? rtg : rpc + 4));
      if (rv && (h || rt)) begin
        m_v[i] = 1'b1; m_tag[i] = rpc >> 6; m_h[i] = rt;
        if (rt) m_t[i] = rtg;
      end
    end
  endtask

  localparam int unsigned PA = 32'h0000_1000;
  localparam int unsigned PB = 32'h0000_1040;
  localparam int unsigned PC = 32'h0000_2008;

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail + 1, n_checks + 1);
    $finish;
  end

  initial begin
    rst = 1'b1; fetch_pc = 0; res_valid = 0; res_pc = 0; res_taken = 0; res_target = 0;
    m_mp = 1'b0;
    step("R10", 1, 0, 0, 0, 0, 0);
    step("R1",  0, PA, 0, 0, 0, 0);
    step("R3",  0, PC, 1, PC, 0, 32'h5000);
    step("R3",  0, PC, 0, 0, 0, 0);
    step("R7",  0, PA, 1, PA, 1, 32'h3000);
    step("R2",  0, PA, 0, 0, 0, 0);
    step("R9",  0, PA + 2, 1, PA, 1, 32'h3000);
    step("R8",  0, PA, 1, PA, 0, 0);
    step("R4",  0, PA, 1, PA, 1, 32'h3100);
    step("R5",  0, PA, 1, PB, 1, 32'h4000);
    step("R6",  0, PB, 0, 0, 0, 0);
    step("R6",  0, PA, 1, PB, 1, 32'h4444);
    step("R8",  0, PB, 0, 0, 0, 0);
    step("R10", 1, 0, 0, 0, 0, 0);
    step("R10", 0, PB, 0, 0, 0, 0);
    for (int k = 0; k < 400; k++) begin
      int unsigned pcs [4] = '{PA, PB, PC, 32'h0000_3004};
      int unsigned fp = pcs[$urandom_range(0, 3)];
      int unsigned rp = pcs[$urandom_range(0, 3)];
      step("R8", 0, fp, 1'($urandom_range(0, 1)), rp, 1'($urandom_range(0, 1)),
           32'h6000 + 32'($urandom_range(0, 3)) * 16);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule